// File: doc/BRIEF.md
# Block Cipher Operation Sequencer

This block is the register-mapped control and status front end of a block-cipher accelerator. Software programs a block count, a per-block processing time and an operation kind. It then writes a start command. The block stands in for the cipher datapath: it consumes one 16-byte block every programmed number of cycles. After the last block it posts completion status and can raise a level interrupt.

Status and error flags are sticky. Software clears them by writing ones, so writing back the value just read clears every flag that was pending. Misuse during a running operation is rejected and recorded in an error register:

- a second start command;
- a rewrite of the count, delay or kind registers.

Recorded errors also raise a summary bit in interrupt status. That bit can drive the interrupt line.

Register words, by write/read address:

| Address | Register | Contents |
|---|---|---|
| 0 | start command | reads 0 |
| 1 | block count | minus one |
| 2 | block delay | |
| 3 | kind | bit 0: 1 = exponent-type |
| 4 | interrupt enable | |
| 5 | interrupt status | |
| 6 | flags | |
| 7 | error status | |

Top module: `opseq_top`

## Requirements
- R1: After reset every register reads zero, the busy flag (flags bit 2) is 0 and `irq` is 0.
- R2: Writing exactly 1 to address 0 while idle starts an operation. The busy flag then reads 1 for (N+1)*(D+1) consecutive cycles, where N is the block count register (blocks minus one) and D is the block delay register.
- R3: When the last block completes, interrupt status bit 4 is set. If the kind register bit 0 is 1, interrupt status bit 1 is also set.
- R4: Writing to interrupt status (address 5) clears each bit written as 1 and leaves bits written as 0 unchanged. Writing back the read value therefore clears all pending flags.
- R5: `irq` is high exactly while some interrupt status bit is set whose enable bit (bit 1, 4 or 16 of address 4) is set. Writing 0 to the enable register masks the line.
- R6: A start command received while busy is ignored, so the running operation's length is unchanged. It sets error status bit 0 and interrupt status bit 16.
- R7: Writes to the block count, delay or kind registers while busy are ignored, so the old value reads back. They set error status bit 1 and interrupt status bit 16.
- R8: Flags bit 0 reads 1 exactly while error status is nonzero. Error status clears with the same write-one-to-clear rule as R4.
- R9: A write to address 0 with any value other than 1 starts nothing and records no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 32 | combinational read data |
| irq | output | 1 | level interrupt |

## Verification
The bench builds the block with a 3-bit block count and a 2-bit delay field. This makes the whole configuration space of 8 counts by 4 delays reachable: every pair is run, and the busy length is compared with (N+1)*(D+1). The runs alternate the operation kind and the interrupt enable, so completion status and interrupt gating are checked in each combination. The same small widths keep operations short enough to inject rejected writes at a known point mid-run, and to confirm afterwards that the run length and the readback values were unaffected.

// File: rtl/opseq_pkg.sv
`timescale 1ns/1ps
package opseq_pkg;
    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_DELAY = 3'd2,
        SEL_KIND  = 3'd3,
        SEL_IEN   = 3'd4,
        SEL_ISTAT = 3'd5,
        SEL_FLAGS = 3'd6,
        SEL_ERR   = 3'd7
    } reg_sel_e;

    localparam int ST_EXP_BIT  = 1;
    localparam int ST_DONE_BIT = 4;
    localparam int ST_FAIL_BIT = 16;
    localparam int FL_FAULT_BIT = 0;
    localparam int FL_BUSY_BIT  = 2;
    localparam int ER_RESTART_BIT = 0;
    localparam int ER_LOCKED_BIT  = 1;

    localparam logic [31:0] IEN_MASK =
        (32'd1 << ST_EXP_BIT) | (32'd1 << ST_DONE_BIT) | (32'd1 << ST_FAIL_BIT);

    typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_e;

    function automatic logic [31:0] sticky_next(
        input logic [31:0] cur,
        input logic        clr_en,
        input logic [31:0] clr_bits,
        input logic [31:0] set_bits);
        logic [31:0] kept;
        kept = clr_en ? (cur & ~clr_bits) : cur;
        return kept | set_bits;
    endfunction
endpackage

// File: rtl/opseq_stepper.sv
`timescale 1ns/1ps
module opseq_stepper #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] last_blk,
    input  logic [DLY_W-1:0] last_cyc,
    output logic             busy,
    output logic             finish
);
    import opseq_pkg::*;

    seq_state_e       state_q;
    logic [CNT_W-1:0] blk_q;
    logic [DLY_W-1:0] cyc_q;
    logic             blk_end;

    assign busy    = (state_q == SQ_RUN);
    assign blk_end = busy && (cyc_q == last_cyc);
    assign finish  = blk_end && (blk_q == last_blk);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            blk_q   <= '0;
            cyc_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q <= SQ_RUN;
                        blk_q   <= '0;
                        cyc_q   <= '0;
                    end
                end
                default: begin
                    if (finish) begin
                        state_q <= SQ_IDLE;
                    end else if (blk_end) begin
                        cyc_q <= '0;
                        blk_q <= blk_q + 1'b1;
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_finish_ends_run_R2: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);
    assert_run_ends_by_finish_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(finish));
endmodule

// File: rtl/opseq_irq.sv
`timescale 1ns/1ps
module opseq_irq #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] enable,
    output logic              irq
);
    assign irq = |(status & enable);
endmodule

// File: rtl/opseq_regs.sv
`timescale 1ns/1ps
module opseq_regs #(
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              finish,
    output logic              go,
    output logic [CNT_W-1:0]  last_blk,
    output logic [DLY_W-1:0]  last_cyc,
    output logic [DATA_W-1:0] istat,
    output logic [DATA_W-1:0] ien
);
    import opseq_pkg::*;

    logic [CNT_W-1:0]  cnt_q;
    logic [DLY_W-1:0]  dly_q;
    logic              kind_q;
    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] istat_q;
    logic [DATA_W-1:0] err_q;

    logic start_cmd;
    logic cfg_wr;
    logic [DATA_W-1:0] err_set;
    logic [DATA_W-1:0] st_set;

    assign start_cmd = wr_en && (wr_addr == SEL_START) && (wr_data == 1);
    assign cfg_wr    = wr_en && ((wr_addr == SEL_COUNT) || (wr_addr == SEL_DELAY)
                                 || (wr_addr == SEL_KIND));
    assign go        = start_cmd && !busy;

    always_comb begin
        err_set = '0;
        err_set[ER_RESTART_BIT] = start_cmd && busy;
        err_set[ER_LOCKED_BIT]  = cfg_wr && busy;
        st_set = '0;
        st_set[ST_DONE_BIT] = finish;
        st_set[ST_EXP_BIT]  = finish && kind_q;
        st_set[ST_FAIL_BIT] = |err_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            dly_q   <= '0;
            kind_q  <= 1'b0;
            ien_q   <= '0;
            istat_q <= '0;
            err_q   <= '0;
        end else begin
            if (cfg_wr && !busy) begin
                case (wr_addr)
                    SEL_COUNT: cnt_q  <= wr_data[CNT_W-1:0];
                    SEL_DELAY: dly_q  <= wr_data[DLY_W-1:0];
                    default:   kind_q <= wr_data[0];
                endcase
            end
            if (wr_en && (wr_addr == SEL_IEN)) begin
                ien_q <= wr_data & IEN_MASK;
            end
            istat_q <= sticky_next(istat_q, wr_en && (wr_addr == SEL_ISTAT), wr_data, st_set);
            err_q   <= sticky_next(err_q, wr_en && (wr_addr == SEL_ERR), wr_data, err_set);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            SEL_COUNT: rd_data[CNT_W-1:0] = cnt_q;
            SEL_DELAY: rd_data[DLY_W-1:0] = dly_q;
            SEL_KIND:  rd_data[0] = kind_q;
            SEL_IEN:   rd_data = ien_q;
            SEL_ISTAT: rd_data = istat_q;
            SEL_FLAGS: begin
                rd_data[FL_FAULT_BIT] = |err_q;
                rd_data[FL_BUSY_BIT]  = busy;
            end
            SEL_ERR:   rd_data = err_q;
            default:   rd_data = '0;
        endcase
    end

    assign last_blk = cnt_q;
    assign last_cyc = dly_q;
    assign istat    = istat_q;
    assign ien      = ien_q;

    assert_finish_posts_done_R3: assert property (@(posedge clk) disable iff (rst)
        finish |=> istat_q[ST_DONE_BIT]);
    assert_restart_flagged_R6: assert property (@(posedge clk) disable iff (rst)
        (start_cmd && busy) |=> (err_q[ER_RESTART_BIT] && istat_q[ST_FAIL_BIT]));
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cnt_q) && $stable(dly_q) && $stable(kind_q)));
    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (istat_q[ST_DONE_BIT] && !(wr_en && (wr_addr == SEL_ISTAT))) |=> istat_q[ST_DONE_BIT]);
endmodule

// File: rtl/opseq_top.sv
`timescale 1ns/1ps
module opseq_top #(
    parameter int CNT_W  = 8,
    parameter int DLY_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             go;
    logic             busy;
    logic             finish;
    logic [CNT_W-1:0] last_blk;
    logic [DLY_W-1:0] last_cyc;
    logic [DATA_W-1:0] istat;
    logic [DATA_W-1:0] ien;

    opseq_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .finish(finish),
        .go(go), .last_blk(last_blk), .last_cyc(last_cyc), .istat(istat), .ien(ien));

    opseq_stepper #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_step (
        .clk(clk), .rst(rst), .go(go), .last_blk(last_blk), .last_cyc(last_cyc),
        .busy(busy), .finish(finish));

    opseq_irq #(.DATA_W(DATA_W)) u_irq (.status(istat), .enable(ien), .irq(irq));

    assert_irq_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && ((wr_addr == 3'd4) || (wr_addr == 3'd5)))) |=> irq);
endmodule

// File: tb/opseq_top_bench.sv
`timescale 1ns/1ps
module opseq_top_bench;
    localparam int CW = 3;
    localparam int DW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    opseq_top #(.CNT_W(CW), .DLY_W(DW), .DATA_W(32)) u_opseq_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run(input int inj, input logic [2:0] a, input logic [31:0] d, output int n);
        logic [31:0] f;
        wr(3'd0, 32'd1);
        n = 0;
        rd(3'd6, f);
        while (f[2] && n < 1000) begin
            if (n == inj) begin
                wr_en = 1'b1; wr_addr = a; wr_data = d;
            end else begin
                wr_en = 1'b0;
            end
            n++;
            @(negedge clk);
            rd(3'd6, f);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 reset reg", v, 32'd0);
        end
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        // R2 R3 R5 R4: full sweep
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 4; d++) begin
                logic kind;
                logic [31:0] en;
                logic [31:0] est;
                kind = ((c + d) % 2) == 1;
                en = (c % 3 == 0) ? 32'h0 : ((c % 3 == 1) ? 32'h10 : 32'h2);
                wr(3'd1, c);
                wr(3'd2, d);
                wr(3'd3, {31'd0, kind});
                wr(3'd4, en);
                run(-1, 3'd0, 0, n);
                check("R2 busy length", n, (c + 1) * (d + 1));
                est = 32'h10 | (kind ? 32'h2 : 32'h0);
                rd(3'd5, v);
                check("R3 done status", v, est);
                check("R5 irq gating", {31'd0, irq}, {31'd0, (en & est) != 0});
                wr(3'd5, 32'h0);
                rd(3'd5, v);
                check("R4 zero write keeps", v, est);
                wr(3'd5, v);
                rd(3'd5, v);
                check("R4 writeback clears", v, 32'd0);
                check("R5 irq after clear", {31'd0, irq}, 32'd0);
            end
        end

        // R5: enable after status pending, then mask
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 0);
        run(-1, 3'd0, 0, n);
        check("R5 masked", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h10);
        check("R5 unmasked", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h0);
        check("R5 mask all", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'hFFFF_FFFF);

        // R6: restart while busy
        wr(3'd1, 3); wr(3'd2, 1); wr(3'd3, 0); wr(3'd4, 32'h1_0000);
        run(2, 3'd0, 32'd1, n);
        check("R6 length unchanged", n, 8);
        rd(3'd7, v);
        check("R6 error bit0", v, 32'h1);
        rd(3'd5, v);
        check("R6 status", v, 32'h1_0010);
        check("R6 irq from fail bit", {31'd0, irq}, 32'd1);
        rd(3'd6, v);
        check("R8 fault flag set", v, 32'h1);
        rd(3'd7, v);
        wr(3'd7, v);
        rd(3'd6, v);
        check("R8 fault flag cleared", v, 32'h0);
        rd(3'd7, v);
        check("R8 error cleared", v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);

        // R7: config writes while busy
        run(1, 3'd1, 32'd6, n);
        check("R7 length", n, 8);
        rd(3'd1, v);
        check("R7 count kept", v, 32'd3);
        rd(3'd7, v);
        check("R7 error bit1", v, 32'h2);
        rd(3'd5, v);
        check("R7 status", v, 32'h1_0010);
        run(3, 3'd3, 32'd1, n);
        rd(3'd3, v);
        check("R7 kind kept", v, 32'd0);
        rd(3'd5, v);
        check("R7 no exp bit", v, 32'h1_0010);
        rd(3'd7, v); wr(3'd7, v);
        wr(3'd5, 32'hFFFF_FFFF);

        // R9: non-one start values
        wr(3'd0, 32'd3);
        rd(3'd6, v);
        check("R9 no start", v, 32'd0);
        wr(3'd0, 32'h8000_0001);
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        check("R9 no start high bit", v, 32'd0);
        rd(3'd7, v);
        check("R9 no error", v, 32'd0);
        rd(3'd5, v);
        check("R9 no status", v, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule